// File: doc/BRIEF.md
# Three-stage pipelined RISC sequencer with delayed jump

This block is the control and datapath sequencer of a small pipelined RISC core. Each cycle it fetches one 32-bit instruction from an instruction memory port. The instruction fetched in one cycle enters execute in the next, so fetch and execute of neighbouring instructions overlap. Register-to-register and immediate arithmetic finish in execute and write the internal 32-entry register file at the end of that cycle. Loads and stores compute their address in execute and use a third stage, one cycle later, on a single data memory port. Load data is written to the register file at the end of that memory stage.

A jump is delayed and never flushes anything. The instruction already fetched behind the jump (the delay slot) always runs. Only the fetch after that slot goes to the jump target. The program, or the compiler that wrote it, is responsible for putting a useful instruction or a NOOP in that slot. The only interlock is a one-cycle stall when the instruction right after a load reads the loaded register.

Both memories answer combinationally in the same cycle as the address. The asynchronous active-low reset is released to the pipeline through a two-flop synchroniser.

Top module: `pipe3_core`

## Requirements
- R1: While reset is asserted, and in the cycles until the pipeline leaves reset, `imem_addr` is 0 and neither `dmem_we` nor `dmem_re` is high. The first fetched address is 0. The execute register starts as the all-zero word, which is a NOOP.
- R2: When there is no stall and no jump, `imem_addr` rises by 4 every cycle.
- R3: The opcode is held in bits [31:26]. Opcode 0 is a register operation: rd=[15:11], ra=[25:21], rb=[20:16], function=[3:0]. The functions are 0 add, 1 subtract (ra-rb), 2 and, 3 or, 4 xor, and 5 signed set-less-than (result 1 or 0). The result is written at the end of execute, and the very next instruction can read it without a stall.
- R4: Opcode 1 writes ra plus the sign-extended 16-bit immediate in [15:0] to the register in [20:16].
- R5: Opcode 2 (load) reads the word at ra+sext(imm) into register [20:16]. Opcode 3 (store) writes register [20:16] to ra+sext(imm). The memory access happens in the cycle after execute. A load that directly follows a store sees the stored data.
- R6: If the instruction right after a load reads the load's destination register as ra or rb, the fetch address holds for exactly one cycle and the dependent instruction gets the loaded value. With one instruction in between, there is no stall.
- R7: Opcode 4 is a jump. The instruction fetched right after it always executes. The fetch after that goes to {delay-slot PC[31:28], [25:0], 2'b00}.
- R8: A jump placed in the delay slot of another jump takes effect after its own delay slot. The fetch order is: first jump, second jump, first target, second target.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: Opcodes 5 to 63 behave as a NOOP. They write no register and make no memory access.
- R11: The data port never reads and writes in the same cycle.
- R12: When a load in its memory stage and an arithmetic instruction in execute write the same register in the same cycle, the arithmetic result (the younger instruction) is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data address of the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the clock edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
A program counter that goes wrong shows at `imem_addr` in the next cycle. The bench compares the fetch trace address by address, so a missed stall, a spurious stall, a jump that takes effect one cycle early or late, or a flushed delay slot is seen at once. A wrong register value or a wrong write priority stays hidden until a store reads that register. For that reason every test program stores each result within one or two instructions of computing it, and the scoreboard compares each store's address and data in the cycle the store reaches the data port. Skipped instructions are stores to addresses the scoreboard does not expect, so an instruction that wrongly executes also shows up as a store mismatch.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int XLEN  = 32;
  localparam int RF_AW = 5;
  localparam int TGT_W = 26;

  typedef enum logic [5:0] {
    OPC_REG  = 6'd0,
    OPC_ADDI = 6'd1,
    OPC_LD   = 6'd2,
    OPC_ST   = 6'd3,
    OPC_JMP  = 6'd4
  } opc_e;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_OR  = 4'd3,
    FN_XOR = 4'd4,
    FN_SLT = 4'd5
  } alu_fn_e;

  typedef struct packed {
    logic             is_reg;
    logic             is_addi;
    logic             is_ld;
    logic             is_st;
    logic             is_jmp;
    logic             use_ra;
    logic             use_rb;
    logic [RF_AW-1:0] ra;
    logic [RF_AW-1:0] rb;
    logic [RF_AW-1:0] wd;
    logic [XLEN-1:0]  imm;
    logic [TGT_W-1:0] tgt;
    alu_fn_e          fn;
  } dec_t;

  typedef struct packed {
    logic             ld;
    logic             st;
    logic [RF_AW-1:0] rd;
    logic [XLEN-1:0]  addr;
    logic [XLEN-1:0]  wdata;
  } mem_stage_t;
endpackage

// File: rtl/p3_rst_sync.sv
module p3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/p3_decode.sv
module p3_decode
  import pipe3_pkg::*;
(
  input  logic [31:0] ir,
  output dec_t        d
);
  always_comb begin
    d        = '0;
    d.ra     = ir[25:21];
    d.rb     = ir[20:16];
    d.imm    = {{(XLEN-16){ir[15]}}, ir[15:0]};
    d.tgt    = ir[TGT_W-1:0];
    d.fn     = FN_ADD;
    case (ir[31:26])
      OPC_REG: begin
        d.is_reg = 1'b1;
        d.use_ra = 1'b1;
        d.use_rb = 1'b1;
        d.wd     = ir[15:11];
        d.fn     = alu_fn_e'(ir[3:0]);
      end
      OPC_ADDI: begin
        d.is_addi = 1'b1;
        d.use_ra  = 1'b1;
        d.wd      = ir[20:16];
      end
      OPC_LD: begin
        d.is_ld  = 1'b1;
        d.use_ra = 1'b1;
        d.wd     = ir[20:16];
      end
      OPC_ST: begin
        d.is_st  = 1'b1;
        d.use_ra = 1'b1;
        d.use_rb = 1'b1;
      end
      OPC_JMP: d.is_jmp = 1'b1;
      default: d.is_reg = 1'b0;
    endcase
  end
endmodule

// File: rtl/p3_alu.sv
module p3_alu
  import pipe3_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y
);
  logic lt;

  always_comb begin
    lt = $signed(a) < $signed(b);
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_SLT:  y = {{(W-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/p3_regfile.sv
module p3_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] wa_a,
  input  logic [W-1:0]  wd_a,
  input  logic          we_b,
  input  logic [AW-1:0] wa_b,
  input  logic [W-1:0]  wd_b,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);
  localparam int N = 1 << AW;

  logic [N*W-1:0] flat;

  assign flat[W-1:0] = '0;

  for (genvar gi = 1; gi < N; gi++) begin : g_reg
    logic          hit_a;
    logic          hit_b;
    logic [W-1:0]  nxt;
    logic [W-1:0]  q;

    always_comb begin
      hit_a = we_a && (wa_a == AW'(gi));
      hit_b = we_b && (wa_b == AW'(gi));
      nxt   = hit_a ? wd_a : wd_b;
    end

    always_ff @(posedge clk) begin
      if (hit_a || hit_b) q <= nxt;
    end

    assign flat[gi*W +: W] = q;
  end

  assign rd0 = flat[ra0*W +: W];
  assign rd1 = flat[ra1*W +: W];
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata
);
  logic             rst_sync_n;
  logic [XLEN-1:0]  pc_q, pc_d;
  logic [31:0]      ir_q, ir_d;
  mem_stage_t       m_q, m_d;
  logic             pc_en, ir_en;
  logic             stall, jmp, e_we;
  dec_t             d;
  logic [XLEN-1:0]  ra_val, rb_val, alu_b, alu_y;
  alu_fn_e          alu_fn;

  p3_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  p3_decode u_dec (
    .ir(ir_q),
    .d (d)
  );

  p3_regfile #(.W(XLEN), .AW(RF_AW)) u_rf (
    .clk (clk),
    .we_a(e_we),
    .wa_a(d.wd),
    .wd_a(alu_y),
    .we_b(m_q.ld),
    .wa_b(m_q.rd),
    .wd_b(dmem_rdata),
    .ra0 (d.ra),
    .ra1 (d.rb),
    .rd0 (ra_val),
    .rd1 (rb_val)
  );

  always_comb begin
    alu_b  = d.is_reg ? rb_val : d.imm;
    alu_fn = d.is_reg ? d.fn : FN_ADD;
  end

  p3_alu #(.W(XLEN)) u_alu (
    .a (ra_val),
    .b (alu_b),
    .fn(alu_fn),
    .y (alu_y)
  );

  // next-state logic
  always_comb begin
    stall = m_q.ld && (m_q.rd != '0) &&
            ((d.use_ra && (d.ra == m_q.rd)) || (d.use_rb && (d.rb == m_q.rd)));
    jmp   = d.is_jmp;
    pc_en = !stall;
    ir_en = !stall;
    pc_d  = jmp ? {pc_q[XLEN-1:XLEN-4], d.tgt, 2'b00} : pc_q + XLEN'(4);
    ir_d  = imem_rdata;
    e_we  = (d.is_reg || d.is_addi) && !stall;
    m_d   = '0;
    if (!stall) begin
      m_d.ld    = d.is_ld;
      m_d.st    = d.is_st;
      m_d.rd    = d.wd;
      m_d.addr  = alu_y;
      m_d.wdata = rb_val;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q <= '0;
      ir_q <= '0;
      m_q  <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= ir_d;
      m_q <= m_d;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = m_q.addr;
  assign dmem_wdata = m_q.wdata;
  assign dmem_we    = m_q.st;
  assign dmem_re    = m_q.ld;
endmodule

// File: rtl/pipe3_core_chk.sv
module pipe3_core_chk (
  input logic        clk,
  input logic        rst_q,
  input logic        stall,
  input logic        jmp,
  input logic [31:0] ir,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we,
  input logic        dmem_re
);
  // R11
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({dmem_we, dmem_re}));

  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!stall && !jmp) |=> (imem_addr == $past(imem_addr) + 32'd4));

  // R6
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    stall |=> !stall);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    stall |=> $stable(imem_addr));

  // R7
  dslot_keep_chk: assert property (@(posedge clk) disable iff (!rst_q)
    jmp |=> (ir == $past(imem_rdata)));

  // R7
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_q)
    jmp |=> (imem_addr[27:2] == $past(ir[25:0])));
endmodule

bind pipe3_core pipe3_core_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_sync_n),
  .stall     (stall),
  .jmp       (jmp),
  .ir        (ir_q),
  .imem_addr (imem_addr),
  .imem_rdata(imem_rdata),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re)
);

// File: tb/sim_pipe3_core.sv
module sim_pipe3_core;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [64];
  logic [31:0] dmem [512];
  logic        pre_we;
  logic [8:0]  pre_idx;
  logic [31:0] pre_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit capture = 0;
  logic [31:0] trace [64];
  int trace_n = 0;
  logic [31:0] exp_trace [16];
  int exp_trace_n = 0;
  string trace_tag;
  logic [31:0] exp_addr_q [$];
  logic [31:0] exp_data_q [$];
  string       exp_tag_q [$];

  pipe3_core u0 (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[10:2]];

  always @(posedge clk) begin
    if (pre_we) dmem[pre_idx] <= pre_val;
    else if (dmem_we) dmem[dmem_addr[10:2]] <= dmem_wdata;
  end

  // encoders
  function automatic logic [31:0] e_reg(input logic [3:0] fn, input logic [4:0] rd,
                                        input logic [4:0] ra, input logic [4:0] rb);
    return {6'd0, ra, rb, rd, 7'd0, fn};
  endfunction
  function automatic logic [31:0] e_addi(input logic [4:0] rd, input logic [4:0] ra, input logic [15:0] imm);
    return {6'd1, ra, rd, imm};
  endfunction
  function automatic logic [31:0] e_ld(input logic [4:0] rd, input logic [4:0] ra, input logic [15:0] imm);
    return {6'd2, ra, rd, imm};
  endfunction
  function automatic logic [31:0] e_st(input logic [4:0] rb, input logic [4:0] ra, input logic [15:0] imm);
    return {6'd3, ra, rb, imm};
  endfunction
  function automatic logic [31:0] e_jmp(input logic [31:0] tgt);
    return {6'd4, tgt[27:2]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_store(input logic [31:0] a, input logic [31:0] v, input string tag);
    exp_addr_q.push_back(a);
    exp_data_q.push_back(v);
    exp_tag_q.push_back(tag);
  endtask

  task automatic preload(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = a[10:2]; pre_val = v;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // monitor: fetch trace and store scoreboard
  always @(negedge clk) begin
    if (rst_n && capture) begin
      if (trace_n < 64) begin
        trace[trace_n] = imem_addr;
        trace_n++;
      end
      if (dmem_we) begin
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "unexpected store (R5 R7 R10)", dmem_addr, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ev;
          string et;
          ea = exp_addr_q.pop_front();
          ev = exp_data_q.pop_front();
          et = exp_tag_q.pop_front();
          check(dmem_addr == ea, {et, " address"}, dmem_addr, ea);
          check(dmem_wdata == ev, {et, " data"}, dmem_wdata, ev);
        end
      end
    end
  end

  task automatic start_prog();
    rst_n = 1'b0;
    capture = 1'b0;
    trace_n = 0;
    exp_trace_n = 0;
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    @(negedge clk);
    // R1
    check(imem_addr == 32'd0, "R1 reset fetch address", imem_addr, 32'd0);
    check({dmem_we, dmem_re} == 2'b00, "R1 reset data port idle", {30'd0, dmem_we, dmem_re}, 32'd0);
  endtask

  task automatic add_trace(input logic [31:0] a);
    exp_trace[exp_trace_n] = a;
    exp_trace_n++;
  endtask

  task automatic run_prog(input int ncyc);
    int start;
    @(negedge clk);
    rst_n = 1'b1;
    capture = 1'b1;
    repeat (ncyc) @(negedge clk);
    capture = 1'b0;
    start = 0;
    while (start + 1 < trace_n && trace[start + 1] == 32'd0) start++;
    for (int i = 0; i < exp_trace_n; i++) begin
      check(trace[start + i] == exp_trace[i], trace_tag, trace[start + i], exp_trace[i]);
    end
    check(exp_addr_q.size() == 0, "missing expected stores", exp_addr_q.size(), 32'd0);
    exp_addr_q.delete();
    exp_data_q.delete();
    exp_tag_q.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    pre_we = 1'b0; pre_idx = '0; pre_val = '0;

    // Program 1: arithmetic, immediates, r0, undefined opcode
    start_prog();
    imem[0]  = e_addi(5'd1, 5'd0, 16'd5);
    imem[1]  = e_addi(5'd2, 5'd0, 16'hFFFD);
    imem[2]  = e_reg(4'd0, 5'd3, 5'd1, 5'd2);
    imem[3]  = e_st(5'd3, 5'd0, 16'h100);
    imem[4]  = e_reg(4'd1, 5'd4, 5'd1, 5'd2);
    imem[5]  = e_st(5'd4, 5'd0, 16'h104);
    imem[6]  = e_reg(4'd2, 5'd5, 5'd1, 5'd2);
    imem[7]  = e_st(5'd5, 5'd0, 16'h108);
    imem[8]  = e_reg(4'd3, 5'd6, 5'd1, 5'd2);
    imem[9]  = e_st(5'd6, 5'd0, 16'h10C);
    imem[10] = e_reg(4'd4, 5'd7, 5'd1, 5'd2);
    imem[11] = e_st(5'd7, 5'd0, 16'h110);
    imem[12] = e_reg(4'd5, 5'd8, 5'd2, 5'd1);
    imem[13] = e_st(5'd8, 5'd0, 16'h114);
    imem[14] = e_addi(5'd0, 5'd0, 16'd9);
    imem[15] = e_st(5'd0, 5'd0, 16'h118);
    imem[16] = {6'h3F, 5'd0, 5'd1, 16'h7777};
    imem[17] = e_st(5'd1, 5'd0, 16'h11C);
    imem[18] = e_jmp(32'h48);
    exp_store(32'h100, 32'd2,          "R3 R4 add after addi");
    exp_store(32'h104, 32'd8,          "R3 sub");
    exp_store(32'h108, 32'd5,          "R3 and");
    exp_store(32'h10C, 32'hFFFF_FFFD,  "R3 or");
    exp_store(32'h110, 32'hFFFF_FFF8,  "R3 xor");
    exp_store(32'h114, 32'd1,          "R3 signed slt");
    exp_store(32'h118, 32'd0,          "R9 r0 stays zero");
    exp_store(32'h11C, 32'd5,          "R10 undefined opcode is NOOP");
    for (int i = 0; i < 6; i++) add_trace(32'(i * 4));
    trace_tag = "R1 R2 sequential fetch";
    run_prog(50);

    // Program 2: delayed jumps
    start_prog();
    imem[0]  = e_addi(5'd1, 5'd0, 16'd1);
    imem[1]  = e_jmp(32'h40);
    imem[2]  = e_addi(5'd1, 5'd1, 16'd10);
    imem[3]  = e_addi(5'd1, 5'd1, 16'd100);
    imem[4]  = e_st(5'd0, 5'd0, 16'h2FC);
    imem[16] = e_st(5'd1, 5'd0, 16'h200);
    imem[17] = e_jmp(32'h50);
    imem[18] = e_jmp(32'h60);
    imem[19] = e_st(5'd0, 5'd0, 16'h2F8);
    imem[20] = e_addi(5'd2, 5'd0, 16'd7);
    imem[21] = e_st(5'd0, 5'd0, 16'h2F4);
    imem[24] = e_st(5'd2, 5'd0, 16'h204);
    imem[25] = e_jmp(32'h64);
    exp_store(32'h200, 32'd11, "R7 delay slot executed, skipped path not");
    exp_store(32'h204, 32'd7,  "R8 jump in delay slot");
    add_trace(32'h00); add_trace(32'h04); add_trace(32'h08); add_trace(32'h40);
    add_trace(32'h44); add_trace(32'h48); add_trace(32'h50); add_trace(32'h60);
    add_trace(32'h64);
    trace_tag = "R7 R8 jump fetch order";
    run_prog(40);

    // Program 3: loads, stores, load-use stall, write priority
    start_prog();
    preload(32'h300, 32'h1234_5678);
    preload(32'h304, 32'h0000_0010);
    imem[0]  = e_ld(5'd1, 5'd0, 16'h300);
    imem[1]  = e_addi(5'd2, 5'd1, 16'd1);
    imem[2]  = e_st(5'd2, 5'd0, 16'h400);
    imem[3]  = e_ld(5'd3, 5'd0, 16'h304);
    imem[4]  = 32'd0;
    imem[5]  = e_reg(4'd0, 5'd4, 5'd3, 5'd3);
    imem[6]  = e_st(5'd4, 5'd0, 16'h404);
    imem[7]  = e_ld(5'd5, 5'd0, 16'h404);
    imem[8]  = e_st(5'd5, 5'd0, 16'h408);
    imem[9]  = e_addi(5'd7, 5'd0, 16'h300);
    imem[10] = e_ld(5'd8, 5'd7, 16'd4);
    imem[11] = 32'd0;
    imem[12] = e_st(5'd8, 5'd7, 16'h40C);
    imem[13] = e_ld(5'd9, 5'd0, 16'h300);
    imem[14] = e_addi(5'd9, 5'd0, 16'd3);
    imem[15] = 32'd0;
    imem[16] = e_st(5'd9, 5'd0, 16'h410);
    imem[17] = e_jmp(32'h44);
    exp_store(32'h400, 32'h1234_5679, "R6 load-use on ra gets loaded value");
    exp_store(32'h404, 32'h0000_0020, "R5 R6 load then gap then use");
    exp_store(32'h408, 32'h0000_0020, "R5 R6 load after store, use as store data");
    exp_store(32'h70C, 32'h0000_0010, "R5 base plus offset");
    exp_store(32'h410, 32'd3,         "R12 younger write wins");
    add_trace(32'h00); add_trace(32'h04); add_trace(32'h08); add_trace(32'h08);
    add_trace(32'h0C); add_trace(32'h10); add_trace(32'h14); add_trace(32'h18);
    trace_tag = "R6 one-cycle stall, none after gap";
    run_prog(60);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule